// File: doc/BRIEF.md
# Configurable LUT Logic Cell

A model of one programmable logic cell in its general-logic mode, suitable for synthesis. Four data inputs feed a 4-input lookup table. The table's 16-bit truth-table mask is a configuration input. The table result leaves the cell combinationally on two pins. One pin is the cell's own logic output. The other is a dedicated chain pin that drives the next cell directly.

One LUT input can be taken either from the third data input or from the carry-in pin. An output register follows the table. It is governed by a group of shared controls: clock, clock enable, asynchronous clear, asynchronous load, synchronous clear and synchronous load. It can capture the table result, the fourth data input (packed use, where the table keeps serving an unrelated function) or a register-chain input from the previous cell. Its value is also forwarded on a register-chain output.

The cell carries no streaming data, so all pins are plain level signals with no valid/ready handshake. The add/subtract control is present only to match the shared control group and has no effect in this mode.

Top module: `lut_cell`

## Requirements
- R1: With `cfg_lut_cin` low, `comb_out` equals `cfg_mask[idx]`, where idx = {din[3], din[2], din[1], din[0]} and din[0] is the least significant bit. The value is combinational, with no clock needed.
- R2: With `cfg_lut_cin` high, index bit 2 is taken from `cin` instead of din[2], so idx = {din[3], cin, din[1], din[0]}. With `cfg_lut_cin` low, `cin` has no effect.
- R3: `lchain_out` always equals `comb_out`.
- R4: While `aclr` is high, `q_out` is 0 at once, with no clock edge needed. This overrides `aload` and all clocked behaviour.
- R5: While `aload` is high and `aclr` is low, `q_out` follows din[2] combinationally. If din[2] is held steady across a clock edge before `aload` falls, `q_out` keeps that value after release.
- R6: At a rising clock edge with `ena` low, `q_out` keeps its value, whatever the data, `sclr` and `sload` inputs are.
- R7: At a rising edge with `ena` high, `sclr` high makes `q_out` 0. This takes priority over `sload`.
- R8: At a rising edge with `ena` high, `sclr` low and `sload` high, `q_out` takes `rchain_in` when `cfg_reg_src` is 2, and din[2] for any other code.
- R9: At a rising edge with `ena` high and both `sclr` and `sload` low, `q_out` captures a source chosen by `cfg_reg_src`: 0 selects the LUT result, 1 selects din[3] (packed), 2 selects `rchain_in`, and 3 selects the LUT result. In packed use `comb_out` still follows R1/R2.
- R10: `rchain_out` always equals `q_out`.
- R11: `addnsub` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock, rising edge active |
| ena | input | 1 | Shared clock enable |
| aclr | input | 1 | Asynchronous clear, active high |
| aload | input | 1 | Asynchronous load from din[2], active high |
| sclr | input | 1 | Synchronous clear, active high |
| sload | input | 1 | Synchronous load, active high |
| addnsub | input | 1 | Add/subtract control, ignored in this mode |
| cfg_mask | input | 16 | LUT truth table, bit n is the output for index n |
| cfg_lut_cin | input | 1 | 1: LUT index bit 2 comes from cin |
| cfg_reg_src | input | 2 | Register data source code |
| din | input | 4 | Data inputs, din[0] is the first |
| cin | input | 1 | Carry-in from the previous cell |
| rchain_in | input | 1 | Register-chain input from the previous cell |
| comb_out | output | 1 | Combinational LUT result |
| lchain_out | output | 1 | LUT-chain output to the next cell |
| q_out | output | 1 | Registered output |
| rchain_out | output | 1 | Register-chain output to the next cell |

## Verification
The LUT outputs are due in the same cycle as their inputs. The bench drives each index and then samples one time unit later, with no clock in between. Asynchronous clear and load are likewise checked one time unit after they are applied, between clock edges, to show that no edge is needed. All clocked register behaviour is due at the first rising edge after the stimulus. Inputs change one time unit after an edge, and `q_out` is compared one time unit after the next edge against a reference computed in the bench from the mask and the control priorities.

// File: rtl/lutcell_pkg.sv
package lutcell_pkg;
  localparam int unsigned LC_INPUTS   = 4;
  localparam int unsigned LC_SWAP_POS = 2;
  localparam int unsigned LC_PACK_POS = 3;

  typedef enum logic [1:0] {
    SRC_LUT    = 2'd0,
    SRC_PACKED = 2'd1,
    SRC_CHAIN  = 2'd2,
    SRC_SPARE  = 2'd3
  } reg_src_e;
endpackage

// File: rtl/lutcell_mux.sv
module lutcell_mux #(
  parameter int unsigned K = 4,
  localparam int unsigned MASK_W = 1 << K
) (
  input  logic [MASK_W-1:0] mask,
  input  logic [K-1:0]      sel,
  output logic              y
);
  // Heap-ordered binary tree: node 1 is the root, leaves sit at MASK_W..2*MASK_W-1.
  logic [2*MASK_W-1:1] tree;

  assign tree[2*MASK_W-1:MASK_W] = mask;

  for (genvar d = 0; d < K; d++) begin : g_depth
    for (genvar n = (1 << d); n < (2 << d); n++) begin : g_node
      assign tree[n] = sel[K-1-d] ? tree[2*n+1] : tree[2*n];
    end
  end

  assign y = tree[1];
endmodule

// File: rtl/lutcell_dsel.sv
module lutcell_dsel
  import lutcell_pkg::*;
(
  input  reg_src_e cfg_src,
  input  logic     lut_y,
  input  logic     pack_bit,
  input  logic     chain_bit,
  input  logic     ld_bit,
  output logic     d_bit,
  output logic     sld_bit
);
  always_comb begin
    unique case (cfg_src)
      SRC_PACKED: d_bit = pack_bit;
      SRC_CHAIN:  d_bit = chain_bit;
      default:    d_bit = lut_y;
    endcase
  end

  assign sld_bit = (cfg_src == SRC_CHAIN) ? chain_bit : ld_bit;
endmodule

// File: rtl/lutcell_reg.sv
module lutcell_reg (
  input  logic clk,
  input  logic aclr,
  input  logic aload,
  input  logic ena,
  input  logic sclr,
  input  logic sload,
  input  logic ald_bit,
  input  logic sld_bit,
  input  logic d_bit,
  output logic q
);
  logic q_reg;

  always_ff @(posedge clk or posedge aclr or posedge aload) begin
    if (aclr)          q_reg <= 1'b0;
    else if (aload)    q_reg <= ald_bit;
    else if (ena) begin
      if (sclr)        q_reg <= 1'b0;
      else if (sload)  q_reg <= sld_bit;
      else             q_reg <= d_bit;
    end
  end

  // Asynchronous load is transparent while held.
  assign q = (aload && !aclr) ? ald_bit : q_reg;

  p_aclr_wins_r4: assert property (@(posedge clk) aclr |-> (q == 1'b0))
    else $error("aclr did not force zero");

  p_aload_follow_r5: assert property (@(posedge clk) disable iff (aclr)
    aload |-> (q == ald_bit))
    else $error("aload value not visible");

  p_hold_r6: assert property (@(posedge clk) disable iff (aclr || aload)
    !ena |=> (q == $past(q)))
    else $error("register moved with enable low");

  p_sclr_r7: assert property (@(posedge clk) disable iff (aclr || aload)
    (ena && sclr) |=> (q == 1'b0))
    else $error("sync clear missed");

  p_sload_r8: assert property (@(posedge clk) disable iff (aclr || aload)
    (ena && !sclr && sload) |=> (q == $past(sld_bit)))
    else $error("sync load missed");

  p_capture_r9: assert property (@(posedge clk) disable iff (aclr || aload)
    (ena && !sclr && !sload) |=> (q == $past(d_bit)))
    else $error("data capture missed");
endmodule

// File: rtl/lut_cell.sv
module lut_cell
  import lutcell_pkg::*;
#(
  parameter int unsigned K = LC_INPUTS,
  localparam int unsigned MASK_W = 1 << K
) (
  input  logic              clk,
  input  logic              ena,
  input  logic              aclr,
  input  logic              aload,
  input  logic              sclr,
  input  logic              sload,
  input  logic              addnsub,
  input  logic [MASK_W-1:0] cfg_mask,
  input  logic              cfg_lut_cin,
  input  logic [1:0]        cfg_reg_src,
  input  logic [K-1:0]      din,
  input  logic              cin,
  input  logic              rchain_in,
  output logic              comb_out,
  output logic              lchain_out,
  output logic              q_out,
  output logic              rchain_out
);
  logic [K-1:0] lut_sel;
  logic         lut_y;
  logic         d_bit;
  logic         sld_bit;
  logic         unused_addnsub;

  // No arithmetic in general-logic mode: the add/subtract control is dropped.
  assign unused_addnsub = addnsub;

  always_comb begin
    lut_sel = din;
    if (cfg_lut_cin) lut_sel[LC_SWAP_POS] = cin;
  end

  lutcell_mux #(.K(K)) u_mux (
    .mask (cfg_mask),
    .sel  (lut_sel),
    .y    (lut_y)
  );

  lutcell_dsel u_dsel (
    .cfg_src   (reg_src_e'(cfg_reg_src)),
    .lut_y     (lut_y),
    .pack_bit  (din[LC_PACK_POS]),
    .chain_bit (rchain_in),
    .ld_bit    (din[LC_SWAP_POS]),
    .d_bit     (d_bit),
    .sld_bit   (sld_bit)
  );

  lutcell_reg u_reg (
    .clk     (clk),
    .aclr    (aclr),
    .aload   (aload),
    .ena     (ena),
    .sclr    (sclr),
    .sload   (sload),
    .ald_bit (din[LC_SWAP_POS]),
    .sld_bit (sld_bit),
    .d_bit   (d_bit),
    .q       (q_out)
  );

  assign comb_out   = lut_y;
  assign lchain_out = lut_y;
  assign rchain_out = q_out;

  p_chain_tracks_r10: assert property (@(posedge clk) disable iff (aclr || aload)
    (ena && !sclr && !sload && cfg_reg_src == 2'd2) |=> (rchain_out == $past(rchain_in)))
    else $error("register chain not forwarded");
endmodule

// File: tb/tb_lut_cell.sv
module tb_lut_cell;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        ena, aclr, aload, sclr, sload, addnsub;
  logic [15:0] cfg_mask;
  logic        cfg_lut_cin;
  logic [1:0]  cfg_reg_src;
  logic [3:0]  din;
  logic        cin, rchain_in;
  logic        comb_out, lchain_out, q_out, rchain_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  lut_cell dut (
    .clk(clk), .ena(ena), .aclr(aclr), .aload(aload), .sclr(sclr), .sload(sload),
    .addnsub(addnsub), .cfg_mask(cfg_mask), .cfg_lut_cin(cfg_lut_cin),
    .cfg_reg_src(cfg_reg_src), .din(din), .cin(cin), .rchain_in(rchain_in),
    .comb_out(comb_out), .lchain_out(lchain_out), .q_out(q_out), .rchain_out(rchain_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic ref_lut(input logic [15:0] m, input logic [3:0] d,
                                   input logic c, input logic use_c);
    logic [3:0] idx;
    idx = d;
    if (use_c) idx[2] = c;
    return m[idx];
  endfunction

  function automatic logic ref_next(input logic q_now);
    logic lut;
    lut = ref_lut(cfg_mask, din, cin, cfg_lut_cin);
    if (!ena)  return q_now;
    if (sclr)  return 1'b0;
    if (sload) return (cfg_reg_src == 2'd2) ? rchain_in : din[2];
    case (cfg_reg_src)
      2'd1:    return din[3];
      2'd2:    return rchain_in;
      default: return lut;
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] masks [14];
    logic exp_q, c_before, q_before;

    ena = 0; aclr = 1; aload = 0; sclr = 0; sload = 0; addnsub = 0;
    cfg_mask = 16'h0; cfg_lut_cin = 0; cfg_reg_src = 2'd0;
    din = 4'h0; cin = 0; rchain_in = 0;
    repeat (3) tick();
    chk("R4 reset q", q_out, 1'b0);
    chk("R10 reset chain", rchain_out, 1'b0);
    aclr = 0;
    tick();

    masks[0] = 16'h0000; masks[1] = 16'hFFFF; masks[2] = 16'h8000;
    masks[3] = 16'h0001; masks[4] = 16'hAAAA; masks[5] = 16'hF0F0;
    for (int i = 6; i < 14; i++) masks[i] = 16'($urandom);

    // R1: full index sweep with cin opposite to din[2]
    for (int mi = 0; mi < 14; mi++) begin
      cfg_mask = masks[mi];
      cfg_lut_cin = 0;
      for (int v = 0; v < 16; v++) begin
        din = 4'(v);
        cin = ~din[2];
        #1;
        chk("R1 lut index", comb_out, cfg_mask[v]);
        chk("R3 lut chain", lchain_out, comb_out);
      end
      // R2: carry-in replaces index bit 2
      cfg_lut_cin = 1;
      for (int v = 0; v < 32; v++) begin
        din = 4'(v);
        cin = v[4];
        #1;
        chk("R2 cin index", comb_out, cfg_mask[{din[3], cin, din[1], din[0]}]);
      end
    end

    // R9: capture sweeps over every source code, addnsub random (R11)
    ena = 1;
    exp_q = q_out;
    for (int s = 0; s < 4; s++) begin
      cfg_reg_src = 2'(s);
      for (int k = 0; k < 24; k++) begin
        cfg_mask = masks[k % 14];
        din = 4'($urandom); cin = 1'($urandom); rchain_in = 1'($urandom);
        cfg_lut_cin = 1'($urandom); addnsub = 1'($urandom);
        #1;
        chk("R9 packed lut still live", comb_out, ref_lut(cfg_mask, din, cin, cfg_lut_cin));
        exp_q = ref_next(exp_q);
        tick();
        chk("R9 capture", q_out, exp_q);
        chk("R10 chain out", rchain_out, exp_q);
      end
    end

    // R6: enable low holds against all sync inputs
    ena = 0;
    for (int k = 0; k < 10; k++) begin
      din = 4'($urandom); rchain_in = 1'($urandom);
      sclr = 1'($urandom); sload = 1'($urandom); cfg_reg_src = 2'($urandom);
      tick();
      chk("R6 hold", q_out, exp_q);
    end

    // R8 then R7
    ena = 1; sclr = 0; sload = 1; cfg_reg_src = 2'd0; din = 4'b0100;
    tick();
    chk("R8 sload data3", q_out, 1'b1);
    sclr = 1; sload = 1;
    tick();
    chk("R7 sclr over sload", q_out, 1'b0);
    sclr = 0; cfg_reg_src = 2'd2; din = 4'b0000; rchain_in = 1;
    tick();
    chk("R8 sload chain", q_out, 1'b1);
    din = 4'b0100; rchain_in = 0;
    tick();
    chk("R8 sload chain not data3", q_out, 1'b0);
    cfg_reg_src = 2'd1; din = 4'b0100;
    tick();
    chk("R8 sload packed uses data3", q_out, 1'b1);
    din = 4'b0000;
    tick();
    chk("R8 sload data3 low", q_out, 1'b0);
    sload = 0;

    // R5 / R4: asynchronous controls, enable low
    ena = 0; cfg_reg_src = 2'd0;
    din = 4'b0100; aload = 1;
    #1; chk("R5 aload immediate", q_out, 1'b1);
    din = 4'b0000;
    #1; chk("R5 aload follows low", q_out, 1'b0);
    din = 4'b0100;
    #1; chk("R5 aload follows high", q_out, 1'b1);
    tick();
    chk("R5 aload across edge", q_out, 1'b1);
    aclr = 1;
    #1; chk("R4 aclr over aload", q_out, 1'b0);
    tick();
    chk("R4 aclr held", q_out, 1'b0);
    aclr = 0;
    #1; chk("R5 aload after aclr", q_out, 1'b1);
    tick();
    aload = 0;
    #1; chk("R5 value kept after release", q_out, 1'b1);
    tick();
    chk("R5 kept across edge", q_out, 1'b1);

    // R11: addnsub toggling leaves outputs untouched
    cfg_mask = 16'h6996; cfg_lut_cin = 0; din = 4'b1011; addnsub = 0;
    #1; c_before = comb_out; q_before = q_out;
    addnsub = 1;
    #1;
    chk("R11 comb unaffected", comb_out, c_before);
    chk("R11 q unaffected", q_out, q_before);
    tick();
    chk("R11 q unaffected after edge", q_out, q_before);
    ena = 1; cfg_reg_src = 2'd0; addnsub = 0;
    exp_q = ref_lut(cfg_mask, din, cin, cfg_lut_cin);
    addnsub = 1;
    tick();
    chk("R11 capture ignores addnsub", q_out, exp_q);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule